// File: doc/BRIEF.md
# Page-Mode DRAM Read Sequencer

This block turns word read requests into the strobe sequence for an asynchronous DRAM. The DRAM takes its address in two halves on the same pins. A request carries a full address, row half above column half, and is accepted through a valid/ready handshake. The block drives the shared address pins and active-low row and column strobes. It captures the word from the DRAM data pins, and each accepted request gets one result, shown by a one-cycle `rd_valid` pulse.

After a read the row stays open. A later request to the same row costs only a new column strobe. A request to another row first closes the open row, then waits until the row cycle time has passed since the last row strobe, then opens the new row. A refresh timer asks for one row refresh per interval, stepping through the rows in order. A refresh is a row strobe with no column strobe. It waits for a read in progress to finish, closes any open row, and then goes ahead of waiting requests. All minimum intervals are given in nanoseconds and rounded up to whole clock cycles.

Top module: `dram_page_reader`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `dram_ras_n` and `dram_cas_n` are high and `rd_valid` is low.
- R2: A request to a closed row is accepted on the edge where `dram_ras_n` falls with the row half on `dram_addr`. `dram_cas_n` falls one cycle later with the column half. `req_ready` is only high while `dram_cas_n` is high, and a column strobe only follows a row strobe.
- R3: The data word is captured no sooner than ceil(60 ns / period) cycles after the row strobe fell and ceil(15 ns / period) cycles after the column strobe fell. For a closed-row access this puts `rd_valid` exactly 8 cycles after the accepting edge at 8 ns.
- R4: A request to the open row makes no new row strobe. Its column strobe falls on the accepting edge, and `rd_valid` follows ceil(15 ns / period) cycles later.
- R5: Successive column strobe falls are at least ceil(35 ns / period) cycles apart.
- R6: Successive row strobe falls, refreshes included, are at least ceil(110 ns / period) cycles apart.
- R7: A request to a row other than the open one closes the open row and opens the requested row with a fresh row strobe.
- R8: A refresh request is raised every floor(REFRESH_NS / (rows x period)) cycles. It is served as a row strobe with no column strobe, to row addresses 0, 1, 2 … in turn. An open row is closed first, so the next access to that row is a full row access.
- R9: `dram_cas_n` is low only while `dram_ras_n` is low.
- R10: Every accepted request yields exactly one `rd_valid` pulse, in acceptance order. Two pulses are never on adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted on this edge |
| req_addr | input | 2*HALF_W | Word address, row half in the upper bits |
| rd_valid | output | 1 | One-cycle result strobe |
| rd_data | output | DATA_W | Captured read word |
| dram_addr | output | HALF_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_dq | input | DATA_W | Data from the DRAM |

## Verification
The assertions check on every cycle that the column strobe stays inside a row strobe and follows it. They also check the row-cycle and column-cycle spacing of strobe falls, that a result pulse comes straight after a column strobe, and that result pulses never touch. The bench's DRAM model only returns the correct word once both access times have elapsed, so the data compare checks the capture point. Exact latencies, the choice between page hit and row reopen, and the refresh row order, spacing and row closing can only be seen through the bench's scenarios.

// File: rtl/dram_pkg.sv
`timescale 1ns/1ps
package dram_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // no row open, RAS high
        ST_ACT,    // RAS just fell, column goes out next
        ST_READ,   // CAS low, waiting for the access times
        ST_OPEN,   // row held open, CAS high
        ST_REF     // refresh row strobe in progress
    } ctl_state_e;
endpackage

// File: rtl/strobe_age_timer.sv
`timescale 1ns/1ps
// Counts cycles since a strobe fell, saturating at LIMIT.
// age_o is the number of cycles elapsed by the next clock edge.
module strobe_age_timer #(
    parameter int LIMIT = 14,
    localparam int AW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall_i,
    output logic [AW-1:0] age_o
);
    localparam logic [AW-1:0] LIM = AW'(LIMIT);

    logic [AW-1:0] age_d, age_q;

    always_comb begin
        if (fall_i)          age_d = AW'(1);
        else if (age_q < LIM) age_d = age_q + AW'(1);
        else                 age_d = age_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= LIM;
        else        age_q <= age_d;
    end

    assign age_o = age_q;
endmodule

// File: rtl/refresh_scheduler.sv
`timescale 1ns/1ps
// Raises a pending flag once per INTERVAL cycles; a grant clears it.
module refresh_scheduler #(
    parameter int INTERVAL = 976,
    localparam int CW = $clog2(INTERVAL)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_i,
    output logic pend_o
);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          pend_d, pend_q;

    always_comb begin
        cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        pend_d = pend_q;
        if (grant_i)        pend_d = 1'b0;
        if (cnt_q == LAST)  pend_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/dram_page_reader.sv
`timescale 1ns/1ps
module dram_page_reader
    import dram_pkg::*;
#(
    parameter int HALF_W     = 10,
    parameter int DATA_W     = 16,
    parameter int T_CLK_NS   = 8,
    parameter int T_RAC_NS   = 60,
    parameter int T_RC_NS    = 110,
    parameter int T_CAC_NS   = 15,
    parameter int T_PC_NS    = 35,
    parameter int REFRESH_NS = 8_000_000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [2*HALF_W-1:0]   req_addr,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    output logic [HALF_W-1:0]     dram_addr,
    output logic                  dram_ras_n,
    output logic                  dram_cas_n,
    input  logic [DATA_W-1:0]     dram_dq
);
    localparam int ADDR_W  = 2 * HALF_W;
    localparam int RAC_CYC = (T_RAC_NS + T_CLK_NS - 1) / T_CLK_NS;
    localparam int RC_CYC  = (T_RC_NS  + T_CLK_NS - 1) / T_CLK_NS;
    localparam int CAC_CYC = (T_CAC_NS + T_CLK_NS - 1) / T_CLK_NS;
    localparam int PC_CYC  = (T_PC_NS  + T_CLK_NS - 1) / T_CLK_NS;
    localparam int ROWS    = 1 << HALF_W;
    localparam int REFI_CYC = REFRESH_NS / (ROWS * T_CLK_NS);
    localparam int RAS_LIM = (RC_CYC > RAC_CYC) ? RC_CYC : RAC_CYC;
    localparam int CAS_LIM = (PC_CYC > CAC_CYC) ? PC_CYC : CAC_CYC;
    localparam int RAS_AW  = $clog2(RAS_LIM + 1);
    localparam int CAS_AW  = $clog2(CAS_LIM + 1);
    localparam logic [RAS_AW-1:0] RC_T  = RAS_AW'(RC_CYC);
    localparam logic [RAS_AW-1:0] RAC_T = RAS_AW'(RAC_CYC);
    localparam logic [CAS_AW-1:0] PC_T  = CAS_AW'(PC_CYC);
    localparam logic [CAS_AW-1:0] CAC_T = CAS_AW'(CAC_CYC);

    typedef struct packed {
        ctl_state_e          state;
        logic                ras_n;
        logic                cas_n;
        logic [HALF_W-1:0]   addr;
        logic [HALF_W-1:0]   row;
        logic [HALF_W-1:0]   col;
        logic [HALF_W-1:0]   ref_row;
        logic                rd_valid;
        logic [DATA_W-1:0]   rd_data;
    } ctl_t;

    ctl_t q, d;
    logic [RAS_AW-1:0] ras_age;
    logic [CAS_AW-1:0] cas_age;
    logic              ref_pend, ref_grant, ready_c;
    logic [HALF_W-1:0] req_row, req_col;

    assign req_row = req_addr[ADDR_W-1:HALF_W];
    assign req_col = req_addr[HALF_W-1:0];

    strobe_age_timer #(.LIMIT(RAS_LIM)) ras_age_i (
        .clk(clk), .rst_n(rst_n), .fall_i(q.ras_n & ~d.ras_n), .age_o(ras_age));

    strobe_age_timer #(.LIMIT(CAS_LIM)) cas_age_i (
        .clk(clk), .rst_n(rst_n), .fall_i(q.cas_n & ~d.cas_n), .age_o(cas_age));

    refresh_scheduler #(.INTERVAL(REFI_CYC)) refresh_i (
        .clk(clk), .rst_n(rst_n), .grant_i(ref_grant), .pend_o(ref_pend));

    always_comb begin
        d           = q;
        d.rd_valid  = 1'b0;
        ref_grant   = 1'b0;
        ready_c     = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (ras_age >= RC_T) begin
                    if (ref_pend) begin
                        ref_grant = 1'b1;
                        d.ras_n   = 1'b0;
                        d.addr    = q.ref_row;
                        d.state   = ST_REF;
                    end else if (req_valid) begin
                        ready_c = 1'b1;
                        d.ras_n = 1'b0;
                        d.addr  = req_row;
                        d.row   = req_row;
                        d.col   = req_col;
                        d.state = ST_ACT;
                    end
                end
            end
            ST_ACT: begin
                if (cas_age >= PC_T) begin
                    d.cas_n = 1'b0;
                    d.addr  = q.col;
                    d.state = ST_READ;
                end
            end
            ST_READ: begin
                if (ras_age >= RAC_T && cas_age >= CAC_T) begin
                    d.rd_data  = dram_dq;
                    d.rd_valid = 1'b1;
                    d.cas_n    = 1'b1;
                    d.state    = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (ref_pend) begin
                    d.ras_n = 1'b1;
                    d.state = ST_IDLE;
                end else if (req_valid) begin
                    if (req_row == q.row) begin
                        if (cas_age >= PC_T) begin
                            ready_c = 1'b1;
                            d.cas_n = 1'b0;
                            d.addr  = req_col;
                            d.col   = req_col;
                            d.state = ST_READ;
                        end
                    end else begin
                        d.ras_n = 1'b1;
                        d.state = ST_IDLE;
                    end
                end
            end
            ST_REF: begin
                if (ras_age >= RAC_T) begin
                    d.ras_n   = 1'b1;
                    d.ref_row = q.ref_row + HALF_W'(1);
                    d.state   = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state    <= ST_IDLE;
            q.ras_n    <= 1'b1;
            q.cas_n    <= 1'b1;
            q.addr     <= '0;
            q.row      <= '0;
            q.col      <= '0;
            q.ref_row  <= '0;
            q.rd_valid <= 1'b0;
            q.rd_data  <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = ready_c;
    assign rd_valid   = q.rd_valid;
    assign rd_data    = q.rd_data;
    assign dram_addr  = q.addr;
    assign dram_ras_n = q.ras_n;
    assign dram_cas_n = q.cas_n;
endmodule

// File: rtl/dram_page_reader_chk.sv
`timescale 1ns/1ps
module dram_page_reader_chk #(
    parameter int RC_CYC = 14,
    parameter int PC_CYC = 5,
    localparam int RW = $clog2(RC_CYC + 1),
    localparam int PW = $clog2(PC_CYC + 1)
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic rd_valid,
    input logic req_ready
);
    localparam logic [RW-1:0] RC_L = RW'(RC_CYC);
    localparam logic [PW-1:0] PC_L = PW'(PC_CYC);

    logic          ras_prev, cas_prev;
    logic [RW-1:0] ras_gap;
    logic [PW-1:0] cas_gap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_prev <= 1'b1;
            cas_prev <= 1'b1;
            ras_gap  <= RC_L;
            cas_gap  <= PC_L;
        end else begin
            ras_prev <= ras_n;
            cas_prev <= cas_n;
            if (ras_prev && !ras_n)  ras_gap <= RW'(1);
            else if (ras_gap < RC_L) ras_gap <= ras_gap + RW'(1);
            if (cas_prev && !cas_n)  cas_gap <= PW'(1);
            else if (cas_gap < PC_L) cas_gap <= cas_gap + PW'(1);
        end
    end

    a_r9_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    a_r2_ras_before_cas: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> !$past(ras_n));

    a_r2_ready_with_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cas_n);

    a_r6_row_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ras_gap >= RC_L);

    a_r5_col_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> cas_gap >= PC_L);

    a_r3_data_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$past(cas_n));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

bind dram_page_reader dram_page_reader_chk #(.RC_CYC(RC_CYC), .PC_CYC(PC_CYC)) chk_i (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .rd_valid(rd_valid), .req_ready(req_ready));

// File: tb/dram_page_reader_tb_top.sv
`timescale 1ns/1ps
module dram_page_reader_tb_top;
    localparam int HW = 4;
    localparam int DW = 16;
    localparam int REF_GAP_MAX_NS = 4000 + 60 * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2*HW-1:0] req_addr = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [HW-1:0] dram_addr;
    logic          dram_ras_n, dram_cas_n;
    logic [DW-1:0] dram_dq = '0;

    int checks = 0, failures = 0, cyc = 0;
    int ras_falls = 0, cas_falls = 0, ref_count = 0;
    logic [DW-1:0] exp_q[$];
    int            lat_q[$];
    int            hs_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_page_reader #(.HALF_W(HW), .DATA_W(DW), .T_CLK_NS(8),
                       .REFRESH_NS(64000)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_dq(dram_dq));

    function automatic logic [DW-1:0] pat(logic [HW-1:0] r, logic [HW-1:0] c);
        return {4'hA, r, ~c, r ^ c};
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // DRAM model: latches halves, checks strobe spacing, drives data late enough
    longint t_ras = -1, t_cas = -1, t_ref = 0, t_rst = 0;
    logic   prev_ras = 1'b1, prev_cas = 1'b1, had_cas = 1'b0;
    logic [HW-1:0] m_row = '0, m_col = '0, exp_ref_row = '0;

    always @(negedge clk) begin
        longint now;
        now = $time - 4;
        if (rst_n) begin
            if (prev_ras && !dram_ras_n) begin
                if (t_ras >= 0) chk(now - t_ras >= 110, "R6", "row strobe spacing ns", now - t_ras, 110);
                t_ras = now; m_row = dram_addr; had_cas = 1'b0; ras_falls++;
            end
            if (prev_cas && !dram_cas_n) begin
                chk(!dram_ras_n, "R9", "column strobe with row strobe low", dram_ras_n, 0);
                if (t_cas >= 0) chk(now - t_cas >= 35, "R5", "column strobe spacing ns", now - t_cas, 35);
                t_cas = now; m_col = dram_addr; had_cas = 1'b1; cas_falls++;
            end
            if (!prev_ras && dram_ras_n && !had_cas) begin
                chk(m_row == exp_ref_row, "R8", "refresh row", m_row, exp_ref_row);
                chk(t_ras - t_ref <= REF_GAP_MAX_NS, "R8", "refresh gap ns", t_ras - t_ref, REF_GAP_MAX_NS);
                exp_ref_row = exp_ref_row + 1'b1;
                t_ref = t_ras;
                ref_count++;
            end
        end
        prev_ras = dram_ras_n;
        prev_cas = dram_cas_n;
        if (!dram_cas_n && ($time + 4 - t_ras >= 60) && ($time + 4 - t_cas >= 15))
            dram_dq = pat(m_row, m_col);
        else
            dram_dq = 16'hDEAD;
    end

    // Monitor: pops expected results in order
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", "unexpected result", 1, 0);
            end else begin
                logic [DW-1:0] e;
                int l, h;
                e = exp_q.pop_front(); l = lat_q.pop_front(); h = hs_q.pop_front();
                chk(rd_data == e, "R10", "read data", rd_data, e);
                if (l >= 0) chk(cyc - h == l, (l == 2) ? "R4" : "R3", "latency cycles", cyc - h, l);
            end
        end
    end

    task automatic send(logic [HW-1:0] r, logic [HW-1:0] c, int lat);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {r, c};
        forever begin
            #3;
            if (req_ready) break;
            @(negedge clk);
        end
        exp_q.push_back(pat(r, c));
        lat_q.push_back(lat);
        hs_q.push_back(cyc + 1);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    endtask

    initial begin
        int r0, c0;
        logic [15:0] lfsr;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(dram_ras_n == 1'b1, "R1", "ras_n in reset", dram_ras_n, 1);
        chk(dram_cas_n == 1'b1, "R1", "cas_n in reset", dram_cas_n, 1);
        chk(rd_valid == 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
        rst_n = 1'b1;
        t_rst = $time; t_ref = $time;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && !rd_valid, "R1", "idle after reset", 0, 1);

        // R2/R3 closed row access, then R4 page hits
        r0 = ras_falls; c0 = cas_falls;
        send(4'd3, 4'd5, 8);
        send(4'd3, 4'd6, 2);
        send(4'd3, 4'd7, 2);
        send(4'd3, 4'd8, 2);
        drain();
        chk(ras_falls - r0 == 1, "R4", "row strobes for one row", ras_falls - r0, 1);
        chk(cas_falls - c0 == 4, "R2", "column strobes", cas_falls - c0, 4);

        // R7 row changes
        r0 = ras_falls;
        send(4'd9, 4'd1, 8);
        send(4'd3, 4'd2, 8);
        send(4'd9, 4'd1, 8);
        drain();
        chk(ras_falls - r0 == 3, "R7", "row strobes for row changes", ras_falls - r0, 3);

        // R8 refresh while row 9 left open
        r0 = ref_count;
        repeat (1100) @(negedge clk);
        chk(ref_count - r0 >= 2, "R8", "refreshes while idle", ref_count - r0, 2);
        r0 = ras_falls;
        send(4'd9, 4'd4, 8);
        drain();
        chk(ras_falls - r0 == 1, "R8", "row reopened after refresh", ras_falls - r0, 1);

        // R10 mixed stream across refreshes
        lfsr = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send({2'b01, lfsr[1:0]}, lfsr[7:4], -1);
        end
        drain();
        chk(exp_q.size() == 0, "R10", "results outstanding", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule